// File: doc/BRIEF.md
# ECC-Protected Simple Dual-Port RAM

This block is a 2048-entry, 32-bit memory with one write port and one read port. Each port runs on its own clock. Every word is written with seven check bits from an extended Hamming code: six position checks and one overall parity bit. On a read, the check bits are tested against the data. A single flipped bit, in the data or in the check bits, is repaired on the way out and reported. Two flipped bits are reported and the data is returned as stored.

Each word also carries two 4-bit side fields. These are stored and returned without protection. The encoder can be switched off so the check bits come from a user input. The decoder can be switched off so the raw word comes out. The encoder's result is also driven on its own output, which lets the code logic serve data that never enters the array.

A repair never touches the array. Each read returns the address it used, aligned with the data. A scrub agent outside the block can use that address to write the corrected word back. An optional output register, with a synchronous active-low reset and a clock enable, adds one read cycle.

Top module: `ecc_sdp_ram`

## Requirements
- R1: With the output register fitted (default), a read issued with rd_en high at rd_clk edge N returns the stored data and both side fields after edge N+1. The outputs are sampled before edge N+2.
- R2: enc_chk bit j, for j = 0 to 5, is the XOR of those data bits whose codeword position has bit j set. Data bit i takes the i-th position in the sequence 1, 2, 3, ... once 1, 2, 4, 8, 16 and 32 are skipped. Bit 6 is the XOR of all 32 data bits and enc_chk[5:0].
- R3: A word with one data bit flipped against its stored check bits reads back corrected, with err_single=1 and err_double=0.
- R4: A word whose stored check bits differ from the correct ones in one bit (any of bits 0 to 6) reads back with the data unchanged and err_single=1.
- R5: A word with two data bits flipped reads back with the data as stored, err_double=1 and err_single=0. The two flags are never high together.
- R6: A correction does not repair the array: a second read of the same location flags the error again.
- R7: rd_addr_echo carries the address of the read whose data it accompanies.
- R8: With enc_en=0 the stored check bits are taken from wr_chk instead of the encoder.
- R9: A read issued with dec_en=0 returns the stored data unchanged with both flags low.
- R10: While rd_en is low the read outputs hold their values, whatever rd_addr does.
- R11: A read and a write to the same address on the same clock edge return the data held before the write.
- R12: oreg_rst_n low at an rd_clk edge clears data, side fields, flags and address echo to zero. oreg_ce low holds all read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 11 | Write location |
| wr_data | input | 32 | Write data |
| wr_aux_a | input | 4 | First side field, stored unprotected |
| wr_aux_b | input | 4 | Second side field, stored unprotected |
| enc_en | input | 1 | 1: store encoder check bits; 0: store wr_chk |
| wr_chk | input | 7 | User check bits used when enc_en is 0 |
| enc_chk | output | 7 | Check bits computed from wr_data |
| rd_clk | input | 1 | Read clock |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 11 | Read location |
| dec_en | input | 1 | 1: decode and correct; 0: raw pass-through |
| oreg_rst_n | input | 1 | Synchronous active-low clear of the output register |
| oreg_ce | input | 1 | Output register clock enable |
| rd_data | output | 32 | Read data, corrected when possible |
| rd_aux_a | output | 4 | First side field read back |
| rd_aux_b | output | 4 | Second side field read back |
| err_single | output | 1 | Single-bit error seen and corrected |
| err_double | output | 1 | Double-bit error seen, not corrected |
| rd_addr_echo | output | 11 | Address of the returned word |

## Verification
A fault in the syndrome logic or in the position map shows up on the first read of an injected-error word. It appears two read cycles after the read is issued, as a wrong data bit or a wrong flag. A fault in the encoder shows up earlier, on enc_chk in the same cycle as wr_data. It also shows on a later clean read, which then raises a flag that should be low. A read stage that drifts with rd_en low, or an address echo that is out of step, corrupts the outputs of the hold and echo checks within one cycle. The output-register clear and enable are checked at the edge they act on.

// File: rtl/ecc_sdp_pkg.sv
// Shared helpers for the extended Hamming code used by the ECC memory.
// Assumes codeword positions are numbered from 1, with check bits at powers of two.
package ecc_sdp_pkg;

    // Number of position check bits needed to protect dw data bits.
    function automatic int ham_bits(input int dw);
        for (int r = 1; r < 16; r++) begin
            if ((1 << r) >= dw + r + 1) return r;
        end
        return 16;
    endfunction

    // True when v is a power of two; v is always at least 1 here.
    function automatic bit is_pow2(input int v);
        return (v & (v - 1)) == 0;
    endfunction

    // Codeword position taken by data bit idx (positions that are powers of two are skipped).
    function automatic int data_pos(input int idx);
        int k;
        k = 0;
        for (int p = 1; p < 4096; p++) begin
            if (!is_pow2(p)) begin
                if (k == idx) return p;
                k++;
            end
        end
        return 0;
    endfunction

endpackage

// File: rtl/secded_enc.sv
// SECDED encoder: computes the position check bits and the overall parity bit for
// one data word. Purely combinational; assumes DATA_W fits the package position map.
module secded_enc #(
    parameter int DATA_W = 32,
    localparam int HAM_W = ecc_sdp_pkg::ham_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [HAM_W:0]    chk_o
);

    logic [HAM_W-1:0] pos_acc;

    // Fold the position of every set data bit into the check accumulator.
    always_comb begin
        pos_acc = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (data_i[i]) pos_acc = pos_acc ^ HAM_W'(ecc_sdp_pkg::data_pos(i));
        end
    end

    // Overall parity covers the data and the position checks together.
    always_comb begin
        chk_o = {(^data_i) ^ (^pos_acc), pos_acc};
    end

endmodule

// File: rtl/secded_dec.sv
// SECDED decoder: compares stored check bits against freshly computed ones, repairs a
// single error and reports single or double errors. Combinational; when enable_i
// is low the data passes unchanged and both flags stay low.
module secded_dec #(
    parameter int DATA_W = 32,
    localparam int HAM_W  = ecc_sdp_pkg::ham_bits(DATA_W),
    localparam int CODE_N = DATA_W + HAM_W
) (
    input  logic              enable_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [HAM_W:0]    chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);

    logic [HAM_W:0]    chk_calc;
    logic [HAM_W-1:0]  syn;
    logic              par_err;
    logic              syn_in_range;
    logic [DATA_W-1:0] flip_mask;

    secded_enc #(.DATA_W(DATA_W)) u_recalc (
        .data_i (data_i),
        .chk_o  (chk_calc)
    );

    // Syndrome and overall-parity mismatch from the stored versus recomputed checks.
    always_comb begin
        syn          = chk_calc[HAM_W-1:0] ^ chk_i[HAM_W-1:0];
        par_err      = chk_calc[HAM_W] ^ chk_i[HAM_W] ^ (^syn);
        syn_in_range = (syn <= HAM_W'(CODE_N));
    end

    // One-hot mask selecting the data bit that the syndrome points at, if any.
    always_comb begin
        flip_mask = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (syn == HAM_W'(ecc_sdp_pkg::data_pos(i))) flip_mask[i] = 1'b1;
        end
    end

    // Classify the word and apply the repair.
    always_comb begin
        data_o   = data_i;
        single_o = 1'b0;
        double_o = 1'b0;
        if (enable_i) begin
            if (par_err) begin
                if (syn_in_range) begin
                    single_o = 1'b1;
                    data_o   = data_i ^ flip_mask;
                end else begin
                    double_o = 1'b1;
                end
            end else if (syn != '0) begin
                double_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdp_array.sv
// Storage array with one write port and one registered read port on separate clocks.
// A same-edge read of a location being written returns the old word. The read
// register and the captured address hold while rd_en_i is low.
module sdp_array #(
    parameter int ADDR_W = 11,
    parameter int WORD_W = 46,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              wr_clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_word_i,
    input  logic              rd_clk,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_word_o,
    output logic [ADDR_W-1:0] rd_addr_o
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Write port: store the whole word at the write address.
    always_ff @(posedge wr_clk) begin
        if (wr_en_i) mem[wr_addr_i] <= wr_word_i;
    end

    // Read port: capture the addressed word together with its address.
    always_ff @(posedge rd_clk) begin
        if (rd_en_i) begin
            rd_word_o <= mem[rd_addr_i];
            rd_addr_o <= rd_addr_i;
        end
    end

endmodule

// File: rtl/ecc_sdp_ram.sv
// ECC-protected simple dual-port RAM. The write side encodes (or takes user check bits)
// and stores data, check bits and two side fields. The read side registers the word,
// decodes it and optionally registers the result once more. Assumes the user rewrites
// corrected words; nothing in the block repairs the array.
module ecc_sdp_ram #(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 32,
    parameter int AUX_W   = 4,
    parameter bit OUT_REG = 1'b1,
    localparam int CHK_W  = ecc_sdp_pkg::ham_bits(DATA_W) + 1
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AUX_W-1:0]  wr_aux_a,
    input  logic [AUX_W-1:0]  wr_aux_b,
    input  logic              enc_en,
    input  logic [CHK_W-1:0]  wr_chk,
    output logic [CHK_W-1:0]  enc_chk,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              dec_en,
    input  logic              oreg_rst_n,
    input  logic              oreg_ce,
    output logic [DATA_W-1:0] rd_data,
    output logic [AUX_W-1:0]  rd_aux_a,
    output logic [AUX_W-1:0]  rd_aux_b,
    output logic              err_single,
    output logic              err_double,
    output logic [ADDR_W-1:0] rd_addr_echo
);

    localparam int WORD_W = DATA_W + CHK_W + 2 * AUX_W;
    localparam int CHK_LO = DATA_W;
    localparam int AUA_LO = DATA_W + CHK_W;
    localparam int AUB_LO = AUA_LO + AUX_W;

    logic [CHK_W-1:0]  chk_sel;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] s1_word;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_data;
    logic [CHK_W-1:0]  s1_chk;
    logic [AUX_W-1:0]  s1_aux_a;
    logic [AUX_W-1:0]  s1_aux_b;
    logic              s1_dec_en;
    logic [DATA_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_double;

    secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data_i (wr_data),
        .chk_o  (enc_chk)
    );

    // Choose the check bits to store and assemble the stored word.
    always_comb begin
        chk_sel = enc_en ? enc_chk : wr_chk;
        wr_word = {wr_aux_b, wr_aux_a, chk_sel, wr_data};
    end

    sdp_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .wr_clk    (wr_clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_word_i (wr_word),
        .rd_clk    (rd_clk),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_word_o (s1_word),
        .rd_addr_o (s1_addr)
    );

    // Keep the decoder mode aligned with the word it applies to.
    always_ff @(posedge rd_clk) begin
        if (rd_en) s1_dec_en <= dec_en;
    end

    // Split the registered word into its fields.
    always_comb begin
        s1_data  = s1_word[DATA_W-1:0];
        s1_chk   = s1_word[CHK_LO +: CHK_W];
        s1_aux_a = s1_word[AUA_LO +: AUX_W];
        s1_aux_b = s1_word[AUB_LO +: AUX_W];
    end

    secded_dec #(.DATA_W(DATA_W)) u_dec (
        .enable_i (s1_dec_en),
        .data_i   (s1_data),
        .chk_i    (s1_chk),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    if (OUT_REG) begin : g_oreg
        // Output register: synchronous clear, then load when enabled.
        always_ff @(posedge rd_clk) begin
            if (!oreg_rst_n) begin
                rd_data      <= '0;
                rd_aux_a     <= '0;
                rd_aux_b     <= '0;
                err_single   <= 1'b0;
                err_double   <= 1'b0;
                rd_addr_echo <= '0;
            end else if (oreg_ce) begin
                rd_data      <= dec_data;
                rd_aux_a     <= s1_aux_a;
                rd_aux_b     <= s1_aux_b;
                err_single   <= dec_single;
                err_double   <= dec_double;
                rd_addr_echo <= s1_addr;
            end
        end
    end else begin : g_direct
        // Direct path: decoder results drive the outputs without another stage.
        always_comb begin
            rd_data      = dec_data;
            rd_aux_a     = s1_aux_a;
            rd_aux_b     = s1_aux_b;
            err_single   = dec_single;
            err_double   = dec_double;
            rd_addr_echo = s1_addr;
        end
    end

endmodule

// File: rtl/ecc_sdp_ram_chk.sv
// Property checker for ecc_sdp_ram, attached through bind. Observes the read stage,
// the decoder results and the read outputs on rd_clk.
module ecc_sdp_ram_chk #(
    parameter int ADDR_W  = 11,
    parameter int DATA_W  = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic              rd_clk,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              oreg_rst_n,
    input logic              oreg_ce,
    input logic [DATA_W-1:0] rd_data,
    input logic              err_single,
    input logic              err_double,
    input logic [ADDR_W-1:0] rd_addr_echo,
    input logic [ADDR_W-1:0] s1_addr,
    input logic [DATA_W-1:0] s1_data,
    input logic              s1_dec_en,
    input logic              dec_single,
    input logic              dec_double
);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge rd_clk) disable iff (!oreg_rst_n)
        !(err_single && err_double)); // R5

    AST_ECHO_CAPTURE: assert property (@(posedge rd_clk) disable iff (!oreg_rst_n)
        rd_en |=> (s1_addr == $past(rd_addr))); // R7

    AST_IDLE_HOLD: assert property (@(posedge rd_clk) disable iff (!oreg_rst_n)
        !rd_en |=> ($stable(s1_data) && $stable(s1_addr))); // R10

    AST_DEC_OFF_QUIET: assert property (@(posedge rd_clk) disable iff (!oreg_rst_n)
        !s1_dec_en |-> (!dec_single && !dec_double)); // R9

    if (OUT_REG) begin : g_oreg_props
        AST_OREG_CLEAR: assert property (@(posedge rd_clk)
            !oreg_rst_n |=> (rd_data == '0 && !err_single && !err_double && rd_addr_echo == '0)); // R12

        AST_OREG_HOLD: assert property (@(posedge rd_clk) disable iff (!oreg_rst_n)
            !oreg_ce |=> ($stable(rd_data) && $stable(err_single) && $stable(rd_addr_echo))); // R12
    end

endmodule

bind ecc_sdp_ram ecc_sdp_ram_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .OUT_REG (OUT_REG)
) u_ecc_sdp_ram_chk (
    .rd_clk       (rd_clk),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .oreg_rst_n   (oreg_rst_n),
    .oreg_ce      (oreg_ce),
    .rd_data      (rd_data),
    .err_single   (err_single),
    .err_double   (err_double),
    .rd_addr_echo (rd_addr_echo),
    .s1_addr      (s1_addr),
    .s1_data      (s1_data),
    .s1_dec_en    (s1_dec_en),
    .dec_single   (dec_single),
    .dec_double   (dec_double)
);

// File: tb/test_ecc_sdp_ram.sv
// Scoreboard bench: driver tasks push expected read results, a monitor pops and
// compares them when the two-cycle read latency has elapsed.
module test_ecc_sdp_ram;

    logic        clk;
    logic        wr_en, enc_en, rd_en, dec_en, oreg_rst_n, oreg_ce;
    logic [10:0] wr_addr, rd_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_aux_a, wr_aux_b;
    logic [6:0]  wr_chk, enc_chk;
    logic [31:0] rd_data;
    logic [3:0]  rd_aux_a, rd_aux_b;
    logic        err_single, err_double;
    logic [10:0] rd_addr_echo;

    ecc_sdp_ram i_ecc_sdp_ram (
        .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_aux_a(wr_aux_a), .wr_aux_b(wr_aux_b), .enc_en(enc_en), .wr_chk(wr_chk),
        .enc_chk(enc_chk), .rd_clk(clk), .rd_en(rd_en), .rd_addr(rd_addr),
        .dec_en(dec_en), .oreg_rst_n(oreg_rst_n), .oreg_ce(oreg_ce),
        .rd_data(rd_data), .rd_aux_a(rd_aux_a), .rd_aux_b(rd_aux_b),
        .err_single(err_single), .err_double(err_double), .rd_addr_echo(rd_addr_echo)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    typedef struct {
        logic [52:0] exp;
        int          due;
        string       req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [52:0] pack_out();
        return {rd_addr_echo, err_single, err_double, rd_aux_b, rd_aux_a, rd_data};
    endfunction

    function automatic logic [52:0] mk(input logic [10:0] a, input logic s, input logic d,
                                       input logic [3:0] xb, input logic [3:0] xa,
                                       input logic [31:0] dat);
        return {a, s, d, xb, xa, dat};
    endfunction

    // Reference check bits, built from the requirement text of R2.
    function automatic logic [6:0] ref_chk(input logic [31:0] d);
        logic [6:0] c;
        int p;
        c = '0;
        p = 0;
        for (int i = 0; i < 32; i++) begin
            p++;
            while ((p & (p - 1)) == 0) p++;
            for (int j = 0; j < 6; j++) if (p[j] && d[i]) c[j] = ~c[j];
        end
        c[6] = (^d) ^ (^c[5:0]);
        return c;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each expected item in the cycle its result is due.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            check(q[0].req, 64'(pack_out()), 64'(q[0].exp));
            void'(q.pop_front());
        end
    end

    // Driver: write one word; caller stands at a falling edge.
    task automatic wr(input logic [10:0] a, input logic [31:0] d, input logic [3:0] xa,
                      input logic [3:0] xb, input logic use_enc, input logic [6:0] c);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_aux_a = xa; wr_aux_b = xb;
        enc_en = use_enc; wr_chk = c;
        @(negedge clk);
        wr_en = 1'b0; enc_en = 1'b1;
    endtask

    // Driver: issue one read and queue what it must return two edges later.
    task automatic rd(input logic [10:0] a, input logic dec, input logic [52:0] exp,
                      input string req);
        item_t it;
        rd_en = 1'b1; rd_addr = a; dec_en = dec;
        it.exp = exp; it.due = cyc + 2; it.req = req;
        q.push_back(it);
        @(negedge clk);
        rd_en = 1'b0; dec_en = 1'b1;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [52:0] snap;
        wr_en = 0; rd_en = 0; enc_en = 1; dec_en = 1; oreg_rst_n = 0; oreg_ce = 1;
        wr_addr = '0; rd_addr = '0; wr_data = '0; wr_aux_a = '0; wr_aux_b = '0; wr_chk = '0;
        repeat (2) @(negedge clk);
        check("R12 reset state", 64'(pack_out()), 64'd0);
        oreg_rst_n = 1;
        @(negedge clk);

        // R2: encoder output for several data patterns.
        wr_data = 32'h0000_0001; #1 check("R2 enc bit0", 64'(enc_chk), 64'(ref_chk(32'h0000_0001)));
        wr_data = 32'h8000_0000; #1 check("R2 enc bit31", 64'(enc_chk), 64'(ref_chk(32'h8000_0000)));
        wr_data = 32'hDEAD_BEEF; #1 check("R2 enc mixed", 64'(enc_chk), 64'(ref_chk(32'hDEAD_BEEF)));
        wr_data = 32'hFFFF_FFFF; #1 check("R2 enc ones", 64'(enc_chk), 64'(ref_chk(32'hFFFF_FFFF)));
        @(negedge clk);

        // R1, R7: clean round trips at varied addresses.
        wr(11'd0,    32'h1234_5678, 4'h1, 4'hE, 1'b1, 7'h0);
        wr(11'd5,    32'hA5A5_0F0F, 4'h2, 4'hD, 1'b1, 7'h0);
        wr(11'd2047, 32'hFFFF_0000, 4'hF, 4'h0, 1'b1, 7'h0);
        wr(11'd100,  32'h0000_0000, 4'h9, 4'h6, 1'b1, 7'h0);
        rd(11'd0,    1'b1, mk(11'd0,    0, 0, 4'hE, 4'h1, 32'h1234_5678), "R1 R7 addr 0");
        rd(11'd5,    1'b1, mk(11'd5,    0, 0, 4'hD, 4'h2, 32'hA5A5_0F0F), "R1 R7 addr 5");
        rd(11'd2047, 1'b1, mk(11'd2047, 0, 0, 4'h0, 4'hF, 32'hFFFF_0000), "R1 R7 addr 2047");
        rd(11'd100,  1'b1, mk(11'd100,  0, 0, 4'h6, 4'h9, 32'h0000_0000), "R1 R7 addr 100");

        // R3, R8: single data-bit errors via user check bits of the true word.
        wr(11'd10, 32'hCAFE_F00D ^ 32'h80,       4'h3, 4'h3, 1'b0, ref_chk(32'hCAFE_F00D));
        wr(11'd11, 32'h0F0F_1234 ^ 32'h8000_0000, 4'h4, 4'h5, 1'b0, ref_chk(32'h0F0F_1234));
        wr(11'd12, 32'h7777_7777 ^ 32'h1,        4'h6, 4'h7, 1'b0, ref_chk(32'h7777_7777));
        rd(11'd10, 1'b1, mk(11'd10, 1, 0, 4'h3, 4'h3, 32'hCAFE_F00D), "R3 bit7");
        rd(11'd11, 1'b1, mk(11'd11, 1, 0, 4'h5, 4'h4, 32'h0F0F_1234), "R3 bit31");
        rd(11'd12, 1'b1, mk(11'd12, 1, 0, 4'h7, 4'h6, 32'h7777_7777), "R3 bit0");

        // R4, R8: single check-bit errors, one position bit and the overall bit.
        wr(11'd20, 32'h1357_9BDF, 4'h8, 4'h1, 1'b0, ref_chk(32'h1357_9BDF) ^ 7'h08);
        wr(11'd21, 32'h2468_ACE0, 4'hA, 4'hB, 1'b0, ref_chk(32'h2468_ACE0) ^ 7'h40);
        rd(11'd20, 1'b1, mk(11'd20, 1, 0, 4'h1, 4'h8, 32'h1357_9BDF), "R4 check bit3");
        rd(11'd21, 1'b1, mk(11'd21, 1, 0, 4'hB, 4'hA, 32'h2468_ACE0), "R4 check bit6");

        // R8: user check bits that are correct give a clean read.
        wr(11'd40, 32'h5555_AAAA, 4'hC, 4'h2, 1'b0, ref_chk(32'h5555_AAAA));
        rd(11'd40, 1'b1, mk(11'd40, 0, 0, 4'h2, 4'hC, 32'h5555_AAAA), "R8 user chk clean");

        // R5: two data bits flipped.
        wr(11'd30, 32'h89AB_CDEF ^ 32'h30, 4'h5, 4'hA, 1'b0, ref_chk(32'h89AB_CDEF));
        rd(11'd30, 1'b1, mk(11'd30, 0, 1, 4'hA, 4'h5, 32'h89AB_CDEF ^ 32'h30), "R5 double");

        // R6: the array keeps its error after a corrected read.
        rd(11'd10, 1'b1, mk(11'd10, 1, 0, 4'h3, 4'h3, 32'hCAFE_F00D), "R6 reread");

        // R9: decoder off returns raw data, flags low.
        rd(11'd10, 1'b0, mk(11'd10, 0, 0, 4'h3, 4'h3, 32'hCAFE_F00D ^ 32'h80), "R9 raw single");
        rd(11'd30, 1'b0, mk(11'd30, 0, 0, 4'hA, 4'h5, 32'h89AB_CDEF ^ 32'h30), "R9 raw double");

        // R11: same-edge read and write of one address returns the old word.
        wr_en = 1; wr_addr = 11'd5; wr_data = 32'h0BAD_CAFE; wr_aux_a = 4'h7; wr_aux_b = 4'h7;
        enc_en = 1;
        rd(11'd5, 1'b1, mk(11'd5, 0, 0, 4'hD, 4'h2, 32'hA5A5_0F0F), "R11 old data");
        wr_en = 0;
        rd(11'd5, 1'b1, mk(11'd5, 0, 0, 4'h7, 4'h7, 32'h0BAD_CAFE), "R11 new data after");
        drain();
        check("R1 scoreboard drained", 64'(q.size()), 64'd0);

        // R10: outputs hold with rd_en low while rd_addr moves.
        snap = pack_out();
        for (int k = 0; k < 5; k++) begin
            rd_addr = 11'(k * 3);
            @(negedge clk);
        end
        check("R10 hold", 64'(pack_out()), 64'(snap));

        // R12: clock enable low holds the outputs through a new read.
        oreg_ce = 0;
        rd_en = 1; rd_addr = 11'd0;
        @(negedge clk);
        rd_en = 0;
        repeat (2) @(negedge clk);
        check("R12 ce hold", 64'(pack_out()), 64'(snap));
        oreg_ce = 1;
        @(negedge clk);
        check("R12 ce load", 64'(pack_out()), 64'(mk(11'd0, 0, 0, 4'hE, 4'h1, 32'h1234_5678)));

        // R12: synchronous clear of the output register.
        oreg_rst_n = 0;
        @(negedge clk);
        check("R12 clear", 64'(pack_out()), 64'd0);
        oreg_rst_n = 1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule